// File: doc/BRIEF.md
# Dual-Channel Reload Down-Counter Timer

This block is a timer peripheral with two independent down-counting channels behind one synchronous register port. Each channel has a control/status word, a live count, and two reload words. A channel is started with a trigger write. It then decrements once every second clock cycle. When a tick arrives while the count is zero, the channel raises an underflow flag. With reload enabled, the channel then copies reload word 1 back into the count and keeps running, which gives periodic events. With reload disabled, it halts at zero, which gives a single timeout.

Software sees one interrupt line per channel. A line is asserted while that channel's underflow flag and interrupt enable are both set. The flag is acknowledged by writing the control word back with the flag bit at 0. Writing a 1 to the flag bit leaves it unchanged, so a read-modify-write that clears other bits cannot lose a pending event. Reads are combinational from the address. Writes take effect on the rising clock edge where the write enable is high.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every register of every channel reads 0 and both interrupt outputs are 0.
- R2: Channel c occupies the 16-byte window at byte address c*0x10. Within a window, offset 0x0 is control/status, 0x4 is the count, 0x8 is reload word 1 and 0xC is reload word 2. Address bits [1:0] are ignored. Windows beyond the last channel read 0 and ignore writes. Reload word 2 is stored and readable but is never loaded into the count.
- R3: The control/status bits are: bit 5 stored output level, bit 4 reload enable, bit 3 interrupt enable, bit 2 underflow flag, bit 1 count enable (reads 1 while the channel runs), and bit 0 trigger, which always reads 0. All other bits read 0.
- R4: A control write with bit 0 and bit 1 both set loads reload word 1 into the count and starts the channel. A control write with bit 0 set and bit 1 clear does not change the count.
- R5: A running channel decrements its count by one every 2 clock cycles. The first decrement occurs on the second rising edge after the trigger edge.
- R6: A tick that arrives while the count is 0 sets the underflow flag. With reload enable set, the count is reloaded from reload word 1 on that edge and counting continues, so events repeat every 2*(reload+1) cycles.
- R7: With reload enable clear, the underflow halts the channel. Count enable reads 0 afterwards and the count stays at 0.
- R8: Interrupt output c is 1 exactly while channel c's underflow flag and interrupt enable are both 1.
- R9: A control write with bit 2 at 0 clears the underflow flag. A control write with bit 2 at 1 leaves the flag unchanged and never sets it.
- R10: A control write with bit 1 at 0 stops the channel at once, and the count then holds its value.
- R11: The two channels are independent: activity on one never changes the other's registers or interrupt.
- R12: The count and both reload words are full 32-bit registers that accept direct writes. A reload value of 0xFFFFFFFF counts down from all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | NUM_CH | Per-channel interrupt, level |

## Verification
The bench measures the reload period edge by edge. A design that counted N instead of N+1 ticks, or that decremented on every clock, would raise the interrupt one or several cycles off the expected edge. It also writes the flag bit as 1 and checks that the flag neither clears nor gets set, which catches a design that treats the bit as plain read/write. Further checks cover a trigger without count enable, an underflow with the interrupt disabled, a one-shot halt that must leave the count at 0, and a stopped channel whose count must not drift. A wrong one-shot design would keep reloading or wrap to all-ones, and a wrong stop would keep counting.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;
   localparam int DATA_W  = 32;
   localparam int WIN_LSB = 4;   // 16-byte window per channel

   // control/status bit positions
   localparam int B_TRG = 0;
   localparam int B_RUN = 1;
   localparam int B_UF  = 2;
   localparam int B_IE  = 3;
   localparam int B_RLD = 4;
   localparam int B_LVL = 5;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_RLD1  = 2'd2,
      SEL_RLD2  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/dual_tmr_prescaler.sv
module dual_tmr_prescaler #(
   parameter int PRESC_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   output logic tick
);
   generate
      if (PRESC_DIV == 1) begin : g_pass
         assign tick = en;
      end else begin : g_div
         localparam int PS_W = $clog2(PRESC_DIV);
         localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESC_DIV - 1);
         logic [PS_W-1:0] ps_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           ps_q <= '0;
            else if (clr)         ps_q <= '0;
            else if (en)          ps_q <= (ps_q == PS_LAST) ? '0 : ps_q + 1'b1;
         end

         assign tick = en && (ps_q == PS_LAST);

         // R5
         tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/dual_tmr_channel.sv
module dual_tmr_channel
   import dual_tmr_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int PRESC_DIV = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_ctrl,
   input  logic                        wr_count,
   input  logic                        wr_rld1,
   input  logic                        wr_rld2,
   input  logic [DATA_W-1:0]           wdata,
   output logic [3:0][DATA_W-1:0]      words,
   output logic                        irq
);
   logic             run_q, rld_q, ie_q, uf_q, lvl_q;
   logic [CNT_W-1:0] cnt_q, rld1_q, rld2_q;
   logic             trig_go, halt_now, tick, at_zero, uf_evt;

   assign trig_go  = wr_ctrl && wdata[B_TRG] && wdata[B_RUN];
   assign halt_now = wr_ctrl && !wdata[B_RUN];
   assign at_zero  = (cnt_q == '0);

   dual_tmr_prescaler #(.PRESC_DIV(PRESC_DIV)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (run_q && !halt_now),
      .clr  (trig_go),
      .tick (tick)
   );

   assign uf_evt = tick && at_zero && !trig_go && !wr_count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         rld_q <= 1'b0;
         ie_q  <= 1'b0;
         uf_q  <= 1'b0;
         lvl_q <= 1'b0;
      end else begin
         if (trig_go)       run_q <= 1'b1;
         else if (wr_ctrl)  run_q <= wdata[B_RUN];
         else if (uf_evt)   run_q <= rld_q;

         if (wr_ctrl) begin
            rld_q <= wdata[B_RLD];
            ie_q  <= wdata[B_IE];
            lvl_q <= wdata[B_LVL];
         end

         if (uf_evt)        uf_q <= 1'b1;
         else if (wr_ctrl)  uf_q <= uf_q && wdata[B_UF];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rld1_q <= '0;
         rld2_q <= '0;
      end else begin
         if (trig_go)        cnt_q <= rld1_q;
         else if (wr_count)  cnt_q <= wdata[CNT_W-1:0];
         else if (uf_evt)    cnt_q <= rld_q ? rld1_q : cnt_q;
         else if (tick)      cnt_q <= cnt_q - 1'b1;

         if (wr_rld1) rld1_q <= wdata[CNT_W-1:0];
         if (wr_rld2) rld2_q <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      words           = '0;
      words[SEL_CTRL][B_LVL] = lvl_q;
      words[SEL_CTRL][B_RLD] = rld_q;
      words[SEL_CTRL][B_IE]  = ie_q;
      words[SEL_CTRL][B_UF]  = uf_q;
      words[SEL_CTRL][B_RUN] = run_q;
      words[SEL_COUNT] = DATA_W'(cnt_q);
      words[SEL_RLD1]  = DATA_W'(rld1_q);
      words[SEL_RLD2]  = DATA_W'(rld2_q);
   end

   assign irq = uf_q && ie_q;

   // R4
   trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_go |=> (run_q && cnt_q == $past(rld1_q)));

   // R6
   uf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uf_q) |-> ($past(cnt_q) == '0));

   // R7
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_evt && !rld_q && !wr_ctrl) |=> (!run_q && cnt_q == '0));

   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((halt_now || (!run_q && !trig_go)) && !wr_count) |=> $stable(cnt_q));

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !at_zero && !trig_go && !wr_count) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dual_tmr_rdmux.sv
module dual_tmr_rdmux
   import dual_tmr_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int CH_IDX_W = 2
) (
   input  logic [CH_IDX_W-1:0]               ch_idx,
   input  logic [1:0]                        sel,
   input  logic [NUM_CH-1:0][3:0][DATA_W-1:0] words,
   output logic [DATA_W-1:0]                 rdata
);
   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_idx == CH_IDX_W'(c)) rdata = words[c][sel];
      end
   end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
   import dual_tmr_pkg::*;
#(
   parameter int NUM_CH    = 2,
   parameter int CNT_W     = 32,
   parameter int ADDR_W    = 6,
   parameter int PRESC_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int CH_IDX_W = ADDR_W - WIN_LSB;

   initial begin
      num_ch_chk: assert (NUM_CH >= 1) else $error("NUM_CH must be at least 1");
      cnt_w_chk:  assert (CNT_W >= 2 && CNT_W <= DATA_W) else $error("CNT_W out of range");
      addr_w_chk: assert (CH_IDX_W >= 1 && (1 << CH_IDX_W) >= NUM_CH)
                  else $error("ADDR_W too small for NUM_CH windows");
      presc_chk:  assert (PRESC_DIV >= 1) else $error("PRESC_DIV must be at least 1");
   end

   logic [CH_IDX_W-1:0]               ch_idx;
   reg_sel_e                          sel;
   logic [1:0]                        unused_addr_lsb;
   logic [NUM_CH-1:0][3:0][DATA_W-1:0] ch_words;

   assign ch_idx          = reg_addr[ADDR_W-1:WIN_LSB];
   assign sel             = reg_sel_e'(reg_addr[3:2]);
   assign unused_addr_lsb = reg_addr[1:0];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit;
         assign hit = reg_we && (ch_idx == CH_IDX_W'(c));

         dual_tmr_channel #(.CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (hit && sel == SEL_CTRL),
            .wr_count(hit && sel == SEL_COUNT),
            .wr_rld1 (hit && sel == SEL_RLD1),
            .wr_rld2 (hit && sel == SEL_RLD2),
            .wdata   (reg_wdata),
            .words   (ch_words[c]),
            .irq     (irq[c])
         );
      end
   endgenerate

   dual_tmr_rdmux #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_rdmux (
      .ch_idx(ch_idx),
      .sel   (reg_addr[3:2]),
      .words (ch_words),
      .rdata (reg_rdata)
   );
endmodule

// File: tb/dual_reload_timer_bench.sv
module dual_reload_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  irq;
   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;   // 50 MHz

   dual_reload_timer u_dual_reload_timer (
      .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
      .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
   );

   // {addr, write data, expected readback}
   localparam logic [69:0] VEC_TBL [0:9] = '{
      {6'h08, 32'hA5A5_0001, 32'hA5A5_0001},  // R2 ch0 reload1
      {6'h0C, 32'h1234_5678, 32'h1234_5678},  // R2 ch0 reload2
      {6'h18, 32'h0000_0010, 32'h0000_0010},  // R2 ch1 reload1
      {6'h1C, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R12 ch1 reload2
      {6'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R12 ch0 count
      {6'h14, 32'h0000_0F0F, 32'h0000_0F0F},  // R12 ch1 count
      {6'h00, 32'hFFFF_FF38, 32'h0000_0038},  // R3 ctrl bits only
      {6'h00, 32'h0000_0020, 32'h0000_0020},  // R3 level bit
      {6'h10, 32'h0000_0024, 32'h0000_0020},  // R9 flag write 1 does not set
      {6'h2D, 32'h0000_0055, 32'h0000_0000}   // R2 empty window
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v, held;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      rd(6'h00, v); chk("R1 ctrl0", v, 32'h0);
      rd(6'h14, v); chk("R1 count1", v, 32'h0);
      rd(6'h08, v); chk("R1 reload1", v, 32'h0);
      chk("R1 irq", {30'b0, irq}, 32'h0);

      // register table walk
      for (int i = 0; i < 10; i++) begin
         wr(VEC_TBL[i][69:64], VEC_TBL[i][63:32]);
         rd(VEC_TBL[i][69:64], v);
         chk($sformatf("R2/R3/R9/R12 vec%0d", i), v, VEC_TBL[i][31:0]);
      end

      // R4 R5 R6 periodic on ch0, reload 5, period 12 cycles
      wr(6'h08, 32'd5);
      wr(6'h00, 32'h1B);                 // k=0
      cyc(1); rd(6'h04, v); chk("R4 loaded", v, 32'd5);
      cyc(1); rd(6'h04, v); chk("R5 first decrement", v, 32'd4);
      cyc(9); rd(6'h04, v); chk("R5 reached zero", v, 32'd0);
      chk("R6 no early irq", {31'b0, irq[0]}, 32'd0);
      cyc(1);                            // k=12
      chk("R8 irq on underflow", {31'b0, irq[0]}, 32'd1);
      rd(6'h00, v); chk("R6 ctrl flag", v, 32'h1E);
      rd(6'h04, v); chk("R6 R2 reload from word1", v, 32'd5);
      wr(6'h00, 32'h1A);                 // k=13 clear flag
      chk("R9 flag cleared", {31'b0, irq[0]}, 32'd0);
      cyc(10);                           // k=23
      chk("R6 period early", {31'b0, irq[0]}, 32'd0);
      cyc(1);                            // k=24
      chk("R6 period", {31'b0, irq[0]}, 32'd1);
      wr(6'h00, 32'h1E);                 // write 1 to flag
      rd(6'h00, v); chk("R9 write one keeps flag", v, 32'h1E);

      // R10 stop holds count
      wr(6'h00, 32'h0);
      rd(6'h04, held);
      rd(6'h00, v); chk("R10 stopped ctrl", v, 32'h0);
      cyc(6);
      rd(6'h04, v); chk("R10 count held", v, held);

      // R7 R11 one-shot on ch1, reload 3
      wr(6'h18, 32'd3);
      wr(6'h10, 32'h0B);                 // k=0
      cyc(7); rd(6'h14, v); chk("R7 zero before underflow", v, 32'd0);
      chk("R8 irq1 not yet", {31'b0, irq[1]}, 32'd0);
      cyc(1);                            // k=8
      chk("R8 irq1 raised", {31'b0, irq[1]}, 32'd1);
      rd(6'h10, v); chk("R7 run cleared", v, 32'h0C);
      rd(6'h04, v); chk("R11 ch0 untouched", v, held);
      chk("R11 irq0 quiet", {31'b0, irq[0]}, 32'd0);
      cyc(6); rd(6'h14, v); chk("R7 count stays zero", v, 32'd0);

      // R4 trigger without count enable
      wr(6'h18, 32'd9);
      wr(6'h10, 32'h01);
      rd(6'h10, v); chk("R3 trigger reads zero", v, 32'h0);
      cyc(4); rd(6'h14, v); chk("R4 trigger alone no load", v, 32'd0);

      // R8 interrupt gated by enable
      wr(6'h18, 32'd2);
      wr(6'h10, 32'h03);                 // k=0
      cyc(6); rd(6'h10, v); chk("R6 flag set no ie", v, 32'h04);
      chk("R8 irq masked", {31'b0, irq[1]}, 32'd0);
      wr(6'h10, 32'h0C);
      chk("R8 irq after enable", {31'b0, irq[1]}, 32'd1);

      // R12 full range
      wr(6'h08, 32'hFFFF_FFFF);
      wr(6'h00, 32'h03);                 // k=0
      rd(6'h04, v); chk("R12 all-ones load", v, 32'hFFFF_FFFF);
      cyc(2); rd(6'h04, v); chk("R12 step1", v, 32'hFFFF_FFFE);
      cyc(2); rd(6'h04, v); chk("R12 step2", v, 32'hFFFF_FFFD);

      finish_run();
   end
endmodule